// File: doc/BRIEF.md
# SPI Command-Class Front End

This block is the serial front door of a command-driven peripheral. A host talks to it as an SPI slave in mode 0. Every transaction opens with a two-byte command word: an opcode, then a parameter. While the host shifts that word in, the block shifts two status bytes back. The top two bits of the opcode pick one of four data-handling classes. The class decides what happens to any bytes that follow in the same transaction.

Class 0 commands always run, even while the device is powered down. Class 1 commands carry no payload, so any extra bytes are thrown away. Class 2 commands stream their payload into a 16-entry FIFO, which firmware drains through a read port. Class 3 commands return data in pairs from a two-byte return register that firmware loads. An open-drain ready/busy line throttles the host. The block pulls it low while the FIFO is full, and also while a class 3 read is waiting for its next pair of bytes.

The serial pins are sampled by the system clock through synchronizers, so the SPI clock must be several times slower than the system clock.

Top module: `spi_cmd_front`

## Requirements
- R1: While the opcode byte is shifted in, MISO carries status byte 0, MSB first, captured when slave select falls. Its bits are: bit 7 = ready (1 when the handshake is released), bit 6 = powered (`pwr_up`), bit 5 = FIFO empty, bit 4 = FIFO full, bits 3:0 = 0. During the parameter byte, MISO carries status byte 1, which is the FIFO fill level zero-extended to 8 bits.
- R2: When the parameter byte completes, exactly one one-cycle pulse appears on either `cmd_valid` or `cmd_reject`, never both. `cmd_op` and `cmd_param` hold the two command bytes, and the class is `cmd_op[7:6]`.
- R3: Class 0 (`cmd_op[7:6]`=00) is issued even when `pwr_up` is low. Classes 1 to 3 with `pwr_up` low produce `cmd_reject`, no `cmd_valid`, and no FIFO write.
- R4: For class 0 and class 1, bytes after the command word are discarded. The FIFO stays unchanged and MISO returns 0x00.
- R5: For class 2, every byte after the command word is written to the FIFO, and `fifo_dout` returns the bytes in arrival order.
- R6: When the FIFO holds 16 entries, `rdy_bsy` is driven low and further payload bytes are dropped. The line is released to high impedance as soon as one entry is popped.
- R7: For class 3, `rdy_bsy` goes low right after the command word and stays low until `ret_load`. The next two bytes on MISO are then `ret_data[15:8]` followed by `ret_data[7:0]`.
- R8: After each returned pair in class 3, `ret_req` pulses once and `rdy_bsy` goes low again until the next `ret_load`.
- R9: If slave select rises before the parameter byte completes, nothing is issued, rejected or written. The next transaction frames from its first bit.
- R10: Slave select rising ends the transaction. It clears a pending class 3 wait, so `rdy_bsy` is released unless the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Device powered-up state |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rdy_bsy | output | 1 | Open-drain ready/busy: 0 = busy, Z = ready |
| cmd_valid | output | 1 | Command issued pulse |
| cmd_reject | output | 1 | Command refused (not powered) pulse |
| cmd_op | output | 8 | Opcode byte of last command |
| cmd_param | output | 8 | Parameter byte of last command |
| ret_req | output | 1 | Request for next class 3 pair |
| ret_load | input | 1 | Return register load strobe |
| ret_data | input | 16 | Return pair, high byte sent first |
| fifo_pop | input | 1 | FIFO read strobe |
| fifo_dout | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO empty flag |

## Verification
The bench drives each class both powered down and powered up. This separates the class 0 exemption from rejection of the other classes. Payload bytes are sent after class 0 and class 1 words as well as class 2 words, so dropping is told apart from queuing. A class 2 burst of eighteen bytes overfills the FIFO, and the bench checks the busy line, the status bytes at full and the release after one pop. Aborts before and inside the parameter byte, and a class 3 read of two pairs ending with a deselect, exercise the framing and the handshake.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    CLS_HW     = 2'd0,
    CLS_CFG    = 2'd1,
    CLS_STREAM = 2'd2,
    CLS_FETCH  = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    RT_IDLE,
    RT_DROP,
    RT_STREAM,
    RT_FETCH
  } route_e;

  typedef enum logic [1:0] {
    IDX_OP,
    IDX_PARAM,
    IDX_DATA
  } byte_idx_e;

  function automatic cmd_class_e class_of(input logic [7:0] op);
    return cmd_class_e'(op[7:6]);
  endfunction

  function automatic logic class_allowed(input cmd_class_e cls, input logic powered);
    return (cls == CLS_HW) || powered;
  endfunction

  function automatic logic [7:0] stat0_byte(input logic ready, input logic powered,
                                            input logic empty, input logic full);
    return {ready, powered, empty, full, 4'b0000};
  endfunction

  function automatic logic [7:0] stat1_byte(input logic [7:0] level);
    return level;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       sel,
  output logic       sel_start,
  output logic       sel_end,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] s_sclk, s_cs_n, s_mosi;
  logic         sclk_q, sel_q;
  logic [2:0]   bit_cnt;
  logic [7:0]   rx_sh, tx_reg;
  logic         sclk_now, mosi_now, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0;
      s_cs_n <= '1;
      s_mosi <= '0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      s_sclk <= {s_sclk[TOP-1:0], sclk};
      s_cs_n <= {s_cs_n[TOP-1:0], cs_n};
      s_mosi <= {s_mosi[TOP-1:0], mosi};
      sclk_q <= sclk_now;
      sel_q  <= sel;
    end
  end

  assign sclk_now  = s_sclk[TOP];
  assign mosi_now  = s_mosi[TOP];
  assign sel       = !s_cs_n[TOP];
  assign sel_start = sel && !sel_q;
  assign sel_end   = !sel && sel_q;
  assign rise      = sel && sclk_now && !sclk_q;
  assign fall      = sel && !sclk_now && sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[6:0], mosi_now};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[6:0], mosi_now};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_reg <= '0;
    else if (tx_load) tx_reg <= tx_byte;
    else if (fall && bit_cnt != 3'd0) tx_reg <= {tx_reg[6:0], 1'b0};
  end

  assign miso = sel ? tx_reg[7] : 1'b0;

endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      level <= level + LVL_W'(do_wr) - LVL_W'(do_rd);
    end
  end

endmodule

// File: rtl/cmd_router.sv
module cmd_router
  import spi_cmd_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up,
  input  logic             sel_start,
  input  logic             sel_end,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             ret_load,
  input  logic [15:0]      ret_data,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic             fifo_wr,
  output logic             cmd_valid,
  output logic             cmd_reject,
  output logic [7:0]       cmd_op,
  output logic [7:0]       cmd_param,
  output logic             ret_req,
  output logic             fetch_wait,
  output logic             busy
);

  byte_idx_e  idx;
  route_e     route;
  logic [7:0] op_q;
  logic [15:0] ret_q;
  logic       want_lo, ret_take;
  cmd_class_e cls;

  assign cls      = class_of(op_q);
  assign ret_take = ret_load && fetch_wait && (route == RT_FETCH);
  assign busy     = fifo_full || fetch_wait;
  assign fifo_wr  = byte_done && (idx == IDX_DATA) && (route == RT_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= IDX_OP;
      route      <= RT_IDLE;
      op_q       <= '0;
      ret_q      <= '0;
      want_lo    <= 1'b0;
      fetch_wait <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_reject <= 1'b0;
      cmd_op     <= '0;
      cmd_param  <= '0;
      ret_req    <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      cmd_reject <= 1'b0;
      ret_req    <= 1'b0;
      if (sel_start || sel_end) begin
        idx        <= IDX_OP;
        route      <= RT_IDLE;
        fetch_wait <= 1'b0;
        want_lo    <= 1'b0;
      end else if (byte_done) begin
        case (idx)
          IDX_OP: begin
            op_q <= rx_byte;
            idx  <= IDX_PARAM;
          end
          IDX_PARAM: begin
            idx       <= IDX_DATA;
            cmd_op    <= op_q;
            cmd_param <= rx_byte;
            if (!class_allowed(cls, pwr_up)) begin
              cmd_reject <= 1'b1;
              route      <= RT_DROP;
            end else begin
              cmd_valid <= 1'b1;
              case (cls)
                CLS_STREAM: route <= RT_STREAM;
                CLS_FETCH: begin
                  route      <= RT_FETCH;
                  fetch_wait <= 1'b1;
                end
                default: route <= RT_DROP;
              endcase
            end
          end
          default: begin
            if (route == RT_FETCH) begin
              if (want_lo) begin
                want_lo <= 1'b0;
              end else begin
                fetch_wait <= 1'b1;
                ret_req    <= 1'b1;
              end
            end
          end
        endcase
      end else if (ret_take) begin
        ret_q      <= ret_data;
        fetch_wait <= 1'b0;
        want_lo    <= 1'b1;
      end
    end
  end

  always_comb begin
    tx_load = 1'b0;
    tx_byte = 8'h00;
    if (sel_start) begin
      tx_load = 1'b1;
      tx_byte = stat0_byte(!busy, pwr_up, fifo_empty, fifo_full);
    end else if (byte_done) begin
      tx_load = 1'b1;
      if (idx == IDX_OP)
        tx_byte = stat1_byte(8'(fifo_level));
      else if (idx == IDX_DATA && route == RT_FETCH && want_lo)
        tx_byte = ret_q[7:0];
    end else if (ret_take) begin
      tx_load = 1'b1;
      tx_byte = ret_data[15:8];
    end
  end

endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_up,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output wire         rdy_bsy,
  output logic        cmd_valid,
  output logic        cmd_reject,
  output logic [7:0]  cmd_op,
  output logic [7:0]  cmd_param,
  output logic        ret_req,
  input  logic        ret_load,
  input  logic [15:0] ret_data,
  input  logic        fifo_pop,
  output logic [7:0]  fifo_dout,
  output logic        fifo_empty
);

  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic             sel, sel_start, sel_end, byte_done;
  logic [7:0]       rx_byte, tx_byte;
  logic             tx_load, fifo_wr, fifo_full, fetch_wait, busy;
  logic [LVL_W-1:0] fifo_level;

  spi_byte_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_load(tx_load), .tx_byte(tx_byte), .sel(sel), .sel_start(sel_start),
    .sel_end(sel_end), .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  cmd_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(rx_byte), .rd_en(fifo_pop),
    .rd_data(fifo_dout), .empty(fifo_empty), .full(fifo_full), .level(fifo_level)
  );

  cmd_router #(.LVL_W(LVL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .sel_start(sel_start), .sel_end(sel_end),
    .byte_done(byte_done), .rx_byte(rx_byte), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .ret_load(ret_load),
    .ret_data(ret_data), .tx_load(tx_load), .tx_byte(tx_byte), .fifo_wr(fifo_wr),
    .cmd_valid(cmd_valid), .cmd_reject(cmd_reject), .cmd_op(cmd_op),
    .cmd_param(cmd_param), .ret_req(ret_req), .fetch_wait(fetch_wait), .busy(busy)
  );

  assign rdy_bsy = busy ? 1'b0 : 1'bz;

endmodule

// File: rtl/spi_cmd_front_chk.sv
module spi_cmd_front_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_up,
  input logic             sel,
  input logic             cmd_valid,
  input logic             cmd_reject,
  input logic [1:0]       cls,
  input logic             ret_req,
  input logic             fetch_wait,
  input logic             busy,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level
);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_reject));

  assert_hw_unpowered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !$past(pwr_up)) |-> (cls == 2'b00));

  assert_reject_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> (cls != 2'b00 && !$past(pwr_up)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_full_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> busy);

  assert_fetch_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls == 2'b11) |-> fetch_wait);

  assert_pair_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> fetch_wait);

  assert_deselect_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !fetch_wait);

endmodule

bind spi_cmd_front spi_cmd_front_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .sel(sel), .cmd_valid(cmd_valid),
  .cmd_reject(cmd_reject), .cls(cmd_op[7:6]), .ret_req(ret_req),
  .fetch_wait(fetch_wait), .busy(busy), .fifo_full(fifo_full), .fifo_level(fifo_level)
);

// File: tb/spi_cmd_front_test.sv
module spi_cmd_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_up = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  wire  rb_line;
  logic cmd_valid, cmd_reject, ret_req;
  logic [7:0] cmd_op, cmd_param;
  logic ret_load = 1'b0;
  logic [15:0] ret_data = '0;
  logic fifo_pop = 1'b0;
  logic [7:0] fifo_dout;
  logic fifo_empty;

  pullup (rb_line);

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .rdy_bsy(rb_line), .cmd_valid(cmd_valid),
    .cmd_reject(cmd_reject), .cmd_op(cmd_op), .cmd_param(cmd_param), .ret_req(ret_req),
    .ret_load(ret_load), .ret_data(ret_data), .fifo_pop(fifo_pop),
    .fifo_dout(fifo_dout), .fifo_empty(fifo_empty)
  );

  int n_checks = 0, n_fail = 0;
  int n_cmd = 0, n_rej = 0, n_req = 0;
  logic [7:0] last_op = '0, last_param = '0;
  logic [7:0] exp_q[$];
  logic pop_en = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st0(input logic rdy, input logic pw, input logic em, input logic fu);
    logic [7:0] v = 8'h00;
    v[7] = rdy; v[6] = pw; v[5] = em; v[4] = fu;
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin n_cmd++; last_op = cmd_op; last_param = cmd_param; end
      if (cmd_reject) n_rej++;
      if (ret_req) n_req++;
    end
  end

  // scoreboard monitor: pops FIFO and compares with expected queue (R5)
  always @(negedge clk) begin
    if (pop_en && !fifo_empty) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected fifo byte", fifo_dout, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(fifo_dout == e, "R5 fifo order", fifo_dout, e);
      end
      fifo_pop = 1'b1;
    end else begin
      fifo_pop = 1'b0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin();
    cs_n = 1'b0;
    idle(2*HALF);
  endtask

  task automatic spi_end();
    idle(HALF);
    cs_n = 1'b1;
    idle(4*HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      idle(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  // driver: one full transaction; payload bytes up to n_keep are pushed as expected
  task automatic xfer(input logic [7:0] op, input logic [7:0] prm, input int n_pay,
                      input logic [7:0] base, input int n_keep,
                      output logic [7:0] s0, output logic [7:0] s1, output int nz_pay);
    logic [7:0] r;
    nz_pay = 0;
    spi_begin();
    spi_byte(op, s0);
    spi_byte(prm, s1);
    for (int k = 0; k < n_pay; k++) begin
      if (k < n_keep) exp_q.push_back(base + 8'(k));
      spi_byte(base + 8'(k), r);
      if (r != 8'h00) nz_pay++;
    end
    spi_end();
  endtask

  task automatic load_ret(input logic [15:0] v);
    ret_data = v;
    ret_load = 1'b1;
    idle(1);
    ret_load = 1'b0;
    idle(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] s0, s1, r0, r1;
    int nz, c0, c1;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    check(rb_line === 1'b1, "R6 reset ready released", rb_line, 1);
    check(fifo_empty, "R5 reset fifo empty", fifo_empty, 1);
    check(n_cmd == 0, "R2 reset no command", n_cmd, 0);

    // powered down: class 0 runs, others rejected
    xfer(8'h05, 8'h11, 0, 8'h00, 0, s0, s1, nz);
    check(s0 == st0(1, 0, 1, 0), "R1 status0 unpowered", s0, st0(1, 0, 1, 0));
    check(s1 == 8'h00, "R1 status1 empty", s1, 0);
    check(n_cmd == 1 && last_op == 8'h05, "R3 class0 while unpowered", last_op, 8'h05);
    check(last_param == 8'h11, "R2 parameter byte", last_param, 8'h11);
    xfer(8'h41, 8'h22, 0, 8'h00, 0, s0, s1, nz);
    check(n_rej == 1 && n_cmd == 1, "R3 class1 rejected", n_rej, 1);
    xfer(8'h80, 8'h01, 2, 8'h55, 0, s0, s1, nz);
    check(n_rej == 2 && n_cmd == 1, "R3 class2 rejected", n_rej, 2);
    check(fifo_empty, "R3 rejected payload not queued", fifo_empty, 1);

    pwr_up = 1'b1;
    idle(2);
    xfer(8'h42, 8'h33, 2, 8'h77, 0, s0, s1, nz);
    check(s0 == st0(1, 1, 1, 0), "R1 status0 powered", s0, st0(1, 1, 1, 0));
    check(n_cmd == 2 && last_op == 8'h42, "R2 class1 issued", last_op, 8'h42);
    check(fifo_empty && nz == 0, "R4 class1 extra bytes dropped", nz, 0);
    xfer(8'h03, 8'h04, 1, 8'h99, 0, s0, s1, nz);
    check(n_cmd == 3 && fifo_empty, "R4 class0 extra bytes dropped", n_cmd, 3);

    // class 2 streaming with draining
    pop_en = 1'b1;
    xfer(8'h81, 8'h00, 5, 8'hA1, 5, s0, s1, nz);
    idle(10);
    check(exp_q.size() == 0 && fifo_empty, "R5 class2 bytes all delivered", exp_q.size(), 0);

    // overfill
    pop_en = 1'b0;
    xfer(8'h82, 8'h00, 18, 8'h10, 16, s0, s1, nz);
    check(rb_line === 1'b0, "R6 full drives busy", rb_line, 0);
    xfer(8'h00, 8'h00, 0, 8'h00, 0, s0, s1, nz);
    check(s0 == st0(0, 1, 0, 1), "R1 status0 full", s0, st0(0, 1, 0, 1));
    check(s1 == 8'h10, "R1 status1 level 16", s1, 8'h10);
    pop_en = 1'b1;
    idle(3);
    check(rb_line === 1'b1, "R6 release after one pop", rb_line, 1);
    idle(40);
    check(exp_q.size() == 0 && fifo_empty, "R6 overflow bytes dropped", exp_q.size(), 0);

    // aborts
    c0 = n_cmd; c1 = n_rej;
    spi_begin(); spi_byte(8'h83, r0); spi_end();
    spi_begin(); spi_byte(8'hC1, r0); spi_bits(8'hF0, 4, r1); spi_end();
    check(n_cmd == c0 && n_rej == c1 && fifo_empty, "R9 abort issues nothing", n_cmd, c0);
    xfer(8'h04, 8'h44, 0, 8'h00, 0, s0, s1, nz);
    check(n_cmd == c0 + 1 && last_param == 8'h44, "R9 framing restarts", last_param, 8'h44);

    // class 3 read of two pairs
    spi_begin();
    spi_byte(8'hC5, r0);
    spi_byte(8'h01, r1);
    idle(4);
    check(rb_line === 1'b0, "R7 busy after fetch command", rb_line, 0);
    load_ret(16'hBEEF);
    check(rb_line === 1'b1, "R7 ready after load", rb_line, 1);
    spi_byte(8'h00, r0);
    spi_byte(8'h00, r1);
    check(r0 == 8'hBE, "R7 return high byte", r0, 8'hBE);
    check(r1 == 8'hEF, "R7 return low byte", r1, 8'hEF);
    idle(4);
    check(rb_line === 1'b0 && n_req == 1, "R8 busy and request after pair", n_req, 1);
    load_ret(16'h1234);
    spi_byte(8'h00, r0);
    spi_byte(8'h00, r1);
    check(r0 == 8'h12 && r1 == 8'h34, "R8 second pair", {r0, r1}, 16'h1234);
    idle(4);
    check(rb_line === 1'b0, "R8 busy before third pair", rb_line, 0);
    spi_end();
    check(rb_line === 1'b1, "R10 deselect releases busy", rb_line, 1);

    summary();
  end

endmodule